// File: doc/BRIEF.md
# Presettable Cascadable Binary Counter

This block is a synchronous up-counter built from 4-bit stages that all share one rising-edge clock. On every edge each stage either clears, loads a parallel value, counts up by one, or holds. Two enables gate counting. The parallel enable reaches every stage. The trickle enable enters the lowest stage and then ripples upward through each stage's terminal-count flag. With this arrangement a chain of stages behaves as one wide counter, and the top stage's flag serves as the carry out to a further chain.

A compile-time parameter selects how the active-low clear acts. It can clear the count at once, with no clock, or it can clear on the next rising edge. An optional modulus-limit mode compares the whole count with a constant. When the count equals that constant, the limit logic asserts an internal clear that always acts synchronously, so the counter returns to zero on the following edge. This works with either clear style.

Top module: `cnt_chain`

## Requirements
- R1: With `clr_n` high, `load_n` high and both `en_par` and `en_trk` high, a rising edge adds one to `count`, and all ones wraps to zero.
- R2: With `clr_n` inactive and `load_n` low, a rising edge copies `load_data` into `count`, whatever the levels of `en_par` and `en_trk`.
- R3: With ASYNC_CLR = 0, `clr_n` low makes `count` zero on the next rising edge. This overrides a load and both enables.
- R4: With ASYNC_CLR = 1, `clr_n` low forces `count` to zero at once, without a clock edge.
- R5: With `load_n` high and either `en_par` or `en_trk` low, `count` keeps its value across the edge.
- R6: `carry_out` is high exactly when `en_trk` is high and every bit of `count` is one. It is combinational and follows `en_trk` within a clock period.
- R7: Stage k+1 counts only while stage k reads 15 with its trickle enable high, so carries cross nibble boundaries on the same edge and the whole chain counts as one STAGES*4-bit value.
- R8: With LIMIT_EN = 1, a `count` equal to LIMIT makes the next edge clear the count to zero, overriding load and enables, for either clear style.
- R9: While a clear holds `count` at zero, `carry_out` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock shared by all stages |
| clr_n | input | 1 | Active-low clear; asynchronous or synchronous per ASYNC_CLR |
| load_n | input | 1 | Active-low parallel load |
| en_par | input | 1 | Count enable routed to every stage |
| en_trk | input | 1 | Count enable into the lowest stage; also gates `carry_out` |
| load_data | input | STAGES*4 | Value taken on a load |
| count | output | STAGES*4 | Current counter value |
| carry_out | output | 1 | Terminal count of the top stage, gated by the trickle chain |

## Verification
Two situations are hard to reach from the ports. The first is a carry through every nibble on one edge. The bench loads values just below a nibble boundary and just below full scale, then counts across them. The second is a clear that fires in the middle of a clock period. The bench drops `clr_n` between edges and samples the asynchronous instance before the next edge arrives. The limit instance gets a load on the same edge that its limit clear fires, which shows that the clear wins over the load.

// File: rtl/cnt_pkg.sv
package cnt_pkg;

    localparam int STAGE_W = 4;

    typedef logic [STAGE_W-1:0] nib_t;

    localparam nib_t NIB_FULL = '1;

    typedef enum logic [1:0] {
        M_CLEAR = 2'd0,
        M_LOAD  = 2'd1,
        M_COUNT = 2'd2,
        M_HOLD  = 2'd3
    } mode_e;

    typedef struct packed {
        logic sclr_n;
        logic load_n;
        logic en_p;
        logic en_t;
    } ctl_t;

    // Order of precedence: clear, load, count, hold
    function automatic mode_e pick_mode(ctl_t c);
        mode_e m;
        if (!c.sclr_n)
            m = M_CLEAR;
        else if (!c.load_n)
            m = M_LOAD;
        else if (c.en_p && c.en_t)
            m = M_COUNT;
        else
            m = M_HOLD;
        return m;
    endfunction

    function automatic nib_t next_nib(mode_e m, nib_t q, nib_t d);
        nib_t n;
        case (m)
            M_CLEAR: n = '0;
            M_LOAD:  n = d;
            M_COUNT: n = q + nib_t'(1);
            default: n = q;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/cnt_mode_sel.sv
module cnt_mode_sel
    import cnt_pkg::*;
(
    input  ctl_t  ctl,
    output mode_e mode
);
    always_comb mode = pick_mode(ctl);
endmodule

// File: rtl/cnt_nib_reg.sv
module cnt_nib_reg
    import cnt_pkg::*;
#(
    parameter bit ASYNC_CLR = 1'b0
) (
    input  logic  clk,
    input  logic  aclr_n,
    input  mode_e mode,
    input  nib_t  d,
    output nib_t  q
);
    nib_t nxt;

    always_comb nxt = next_nib(mode, q, d);

    generate
        if (ASYNC_CLR) begin : g_async
            always_ff @(posedge clk or negedge aclr_n) begin
                if (!aclr_n) q <= '0;
                else         q <= nxt;
            end
        end else begin : g_sync
            // aclr_n is tied high by the wrapper in this variant
            always_ff @(posedge clk) begin
                q <= aclr_n ? nxt : '0;
            end
        end
    endgenerate
endmodule

// File: rtl/cnt_tc_dec.sv
module cnt_tc_dec
    import cnt_pkg::*;
(
    input  nib_t q,
    input  logic en_t,
    output logic tc
);
    always_comb tc = en_t && (q == NIB_FULL);
endmodule

// File: rtl/cnt_stage.sv
module cnt_stage
    import cnt_pkg::*;
#(
    parameter bit ASYNC_CLR = 1'b0
) (
    input  logic clk,
    input  logic aclr_n,
    input  logic sclr_n,
    input  logic load_n,
    input  logic en_p,
    input  logic en_t,
    input  nib_t d,
    output nib_t q,
    output logic tc
);
    ctl_t  ctl;
    mode_e mode;

    always_comb begin
        ctl.sclr_n = sclr_n;
        ctl.load_n = load_n;
        ctl.en_p   = en_p;
        ctl.en_t   = en_t;
    end

    cnt_mode_sel u_sel (
        .ctl  (ctl),
        .mode (mode)
    );

    cnt_nib_reg #(.ASYNC_CLR(ASYNC_CLR)) u_reg (
        .clk    (clk),
        .aclr_n (aclr_n),
        .mode   (mode),
        .d      (d),
        .q      (q)
    );

    cnt_tc_dec u_tc (
        .q    (q),
        .en_t (en_t),
        .tc   (tc)
    );

    assert_count_R1: assert property (@(posedge clk) disable iff (!aclr_n)
        (sclr_n && load_n && en_p && en_t) |=> (q == nib_t'($past(q) + nib_t'(1))));

    assert_load_R2: assert property (@(posedge clk) disable iff (!aclr_n)
        (sclr_n && !load_n) |=> (q == $past(d)));

    assert_sclr_R3: assert property (@(posedge clk) disable iff (!aclr_n)
        (!sclr_n) |=> (q == '0));

    assert_hold_R5: assert property (@(posedge clk) disable iff (!aclr_n)
        (sclr_n && load_n && !(en_p && en_t)) |=> $stable(q));
endmodule

// File: rtl/cnt_chain.sv
module cnt_chain
    import cnt_pkg::*;
#(
    parameter int STAGES    = 4,
    parameter bit ASYNC_CLR = 1'b0,
    parameter bit LIMIT_EN  = 1'b0,
    parameter int LIMIT     = 0
) (
    input  logic                        clk,
    input  logic                        clr_n,
    input  logic                        load_n,
    input  logic                        en_par,
    input  logic                        en_trk,
    input  logic [STAGES*STAGE_W-1:0]   load_data,
    output logic [STAGES*STAGE_W-1:0]   count,
    output logic                        carry_out
);
    localparam int W = STAGES * STAGE_W;
    localparam logic [W-1:0] LIMIT_V = W'(LIMIT);

    logic [STAGES:0] trk;
    logic            lim_hit;
    logic            aclr_n;
    logic            sclr_n;

    assign lim_hit = LIMIT_EN && (count == LIMIT_V);

    generate
        if (ASYNC_CLR) begin : g_aclr
            assign aclr_n = clr_n;
            assign sclr_n = !lim_hit;
        end else begin : g_sclr
            assign aclr_n = 1'b1;
            assign sclr_n = clr_n && !lim_hit;
        end
    endgenerate

    assign trk[0] = en_trk;

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        cnt_stage #(.ASYNC_CLR(ASYNC_CLR)) u_stage (
            .clk    (clk),
            .aclr_n (aclr_n),
            .sclr_n (sclr_n),
            .load_n (load_n),
            .en_p   (en_par),
            .en_t   (trk[k]),
            .d      (load_data[k*STAGE_W +: STAGE_W]),
            .q      (count[k*STAGE_W +: STAGE_W]),
            .tc     (trk[k+1])
        );
    end

    assign carry_out = trk[STAGES];

    assert_carry_full_R6: assert property (@(posedge clk)
        carry_out |-> (en_trk && (&count)));

    assert_limit_R8: assert property (@(posedge clk) disable iff (!clr_n)
        lim_hit |=> (count == '0));

    assert_chain_R7: assert property (@(posedge clk) disable iff (!clr_n)
        (LIMIT_EN == 1'b0 && load_n && en_par && en_trk) |=> (count == W'($past(count) + W'(1))));

    assert_clr_carry_R9: assert property (@(posedge clk)
        (count == '0) |-> !carry_out);
endmodule

// File: tb/test_cnt_chain.sv
module test_cnt_chain;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        clr_n  = 1'b0;
    logic        load_n = 1'b1;
    logic        en_par = 1'b0;
    logic        en_trk = 1'b0;
    logic [15:0] din    = '0;

    logic [15:0] q_main;
    logic        c_main;
    logic [3:0]  q_as;
    logic        c_as;
    logic [3:0]  q_lim;
    logic        c_lim;

    cnt_chain #(.STAGES(4), .ASYNC_CLR(1'b0)) i_cnt_chain (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_par(en_par), .en_trk(en_trk),
        .load_data(din), .count(q_main), .carry_out(c_main));

    cnt_chain #(.STAGES(1), .ASYNC_CLR(1'b1)) i_cnt_chain_async (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_par(en_par), .en_trk(en_trk),
        .load_data(din[3:0]), .count(q_as), .carry_out(c_as));

    cnt_chain #(.STAGES(1), .ASYNC_CLR(1'b0), .LIMIT_EN(1'b1), .LIMIT(6)) i_cnt_chain_lim (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_par(en_par), .en_trk(en_trk),
        .load_data(din[3:0]), .count(q_lim), .carry_out(c_lim));

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;
    string tag = "R3";

    int unsigned m_main = 0;
    int unsigned m_as   = 0;
    int unsigned m_lim  = 0;

    task automatic chk(string what, int unsigned act, int unsigned exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic int unsigned step(int unsigned v, int unsigned mask);
        if (!load_n) return int'(din) & mask;
        if (en_par && en_trk) return (v + 1) & mask;
        return v;
    endfunction

    task automatic model_edge();
        int unsigned nl;
        if (!clr_n) begin
            m_main = 0; m_as = 0; m_lim = 0;
        end else begin
            m_main = step(m_main, 32'hFFFF);
            m_as   = step(m_as, 32'hF);
            nl     = (m_lim == 6) ? 0 : step(m_lim, 32'hF);
            m_lim  = nl;
        end
    endtask

    task automatic compare();
        chk("main count", q_main, m_main);
        chk("main carry", c_main, (en_trk && m_main == 32'hFFFF) ? 1 : 0);
        chk("async count", q_as, m_as);
        chk("async carry", c_as, (en_trk && m_as == 15) ? 1 : 0);
        chk("limit count", q_lim, m_lim);
        chk("limit carry", c_lim, (en_trk && m_lim == 15) ? 1 : 0);
    endtask

    task automatic cyc(logic cl, logic ld, logic ep, logic et, logic [15:0] d);
        @(negedge clk);
        clr_n = cl; load_n = ld; en_par = ep; en_trk = et; din = d;
        @(posedge clk);
        model_edge();
        #1;
        compare();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #1_000_000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R3 / R9: reset state through the clear
        tag = "R3";
        cyc(1'b0, 1'b1, 1'b1, 1'b1, 16'h0);
        cyc(1'b0, 1'b1, 1'b1, 1'b1, 16'h0);

        // R1 (and R8 on the limit instance): plain counting
        tag = "R1_R8";
        for (int i = 0; i < 20; i++) cyc(1'b1, 1'b1, 1'b1, 1'b1, 16'h0);

        // R2: load with both enables high, then both low
        tag = "R2";
        cyc(1'b1, 1'b0, 1'b1, 1'b1, 16'h1234);
        cyc(1'b1, 1'b0, 1'b0, 1'b0, 16'hABCD);

        // R5: hold with each enable low in turn
        tag = "R5";
        for (int i = 0; i < 3; i++) cyc(1'b1, 1'b1, 1'b0, 1'b1, 16'h0);
        for (int i = 0; i < 3; i++) cyc(1'b1, 1'b1, 1'b1, 1'b0, 16'h0);

        // R6: carry follows the trickle enable without a clock
        tag = "R6";
        cyc(1'b1, 1'b0, 1'b0, 1'b1, 16'hFFFF);
        #2;
        en_trk = 1'b0;
        #1;
        chk("main carry comb low", c_main, 0);
        en_trk = 1'b1;
        #1;
        chk("main carry comb high", c_main, 1);
        cyc(1'b1, 1'b1, 1'b1, 1'b0, 16'h0);

        // R7: carries across nibble boundaries and full-scale wrap
        tag = "R7";
        cyc(1'b1, 1'b0, 1'b0, 1'b0, 16'h0FFE);
        for (int i = 0; i < 4; i++) cyc(1'b1, 1'b1, 1'b1, 1'b1, 16'h0);
        cyc(1'b1, 1'b0, 1'b0, 1'b0, 16'hFFFD);
        for (int i = 0; i < 5; i++) cyc(1'b1, 1'b1, 1'b1, 1'b1, 16'h0);

        // R3: clear while loading
        tag = "R3";
        cyc(1'b1, 1'b0, 1'b1, 1'b1, 16'h0009);
        cyc(1'b0, 1'b0, 1'b1, 1'b1, 16'h5555);

        // R4: asynchronous clear mid-period
        tag = "R4";
        cyc(1'b1, 1'b0, 1'b0, 1'b1, 16'h0009);
        #2;
        clr_n = 1'b0;
        #1;
        chk("async cleared at once", q_as, 0);
        chk("sync not yet cleared", q_main, 9);
        cyc(1'b0, 1'b1, 1'b1, 1'b1, 16'h0);
        tag = "R9";
        chk("async carry during clear", c_as, 0);
        cyc(1'b1, 1'b1, 1'b1, 1'b1, 16'h0);

        // R8: limit clear beats hold and load
        tag = "R8";
        cyc(1'b1, 1'b0, 1'b0, 1'b0, 16'h0005);
        cyc(1'b1, 1'b1, 1'b0, 1'b0, 16'h0);
        cyc(1'b1, 1'b1, 1'b1, 1'b1, 16'h0);
        cyc(1'b1, 1'b0, 1'b0, 1'b0, 16'h0003);
        chk("limit cleared over load", q_lim, 0);
        for (int i = 0; i < 10; i++) cyc(1'b1, 1'b1, 1'b1, 1'b1, 16'h0);

        finish_run();
    end

endmodule